// File: doc/BRIEF.md
# Bus-Kicked Watchdog Reset Supervisor

This block supervises a system's reset lines. It holds a reset while the supply is not good. It stretches every reset event into a pulse of fixed minimum length. It also runs a watchdog timer that times out unless software keeps addressing a companion serial-bus slave. Each time that slave acknowledges its address byte, it sends a one-cycle strobe, and the strobe restarts the watchdog. An addressed access that carries no data is therefore enough to service the timer.

Time is counted in ticks of a prescaled enable, so both durations are parameters in ticks. The timeout is `TIMEOUT_TICKS`; with a 100 ms tick, the default of 16 gives a 1.6 s window. The pulse length is `PULSE_TICKS`. The same pulse length is used for three cases: power-up, release of an external reset, and recovery after a timeout. The acknowledge strobe, both external reset inputs and the supply flag each pass through a two-stage synchroniser before use. The outputs are a pair of complementary registered resets and a two-bit debug view of the controller state.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: While `rst_ni` is low, the block shows state code 0 (power hold) on `dbg_state_o`, and it drives `reset_o` = 1 and `reset_no` = 0.
- R2: `reset_no` is the complement of `reset_o` in every cycle. `reset_o` is 1 exactly when the state code is not 2 (run).
- R3: When the synchronised supply flag is 0, the next state is power hold (code 0), whatever the current state is. Both counters are cleared.
- R4: Once the supply is good, power hold moves to pulse (code 1) with the pulse count at zero. If ticks arrive every cycle and no external reset is active, pulse lasts `PULSE_TICKS`+1 cycles and then run (code 2) begins with the watchdog count at zero.
- R5: In run, each tick raises the watchdog count by one. The tick that would make the count reach `TIMEOUT_TICKS` moves the state to pulse instead.
- R6: A rising edge of the synchronised acknowledge clears the watchdog count in run, and it takes priority over a tick in the same cycle. If the acknowledge is held high, that counts as a single service.
- R7: Acknowledge edges that arrive during pulse or power hold have no effect. Pulse still lasts `PULSE_TICKS`+1 cycles when ticks arrive every cycle.
- R8: An external reset is active when `ext_rst_ni` = 0 or `ext_rst_i` = 1. In run, an active external reset moves the state to pulse. Pulse ends only after `PULSE_TICKS` ticks have elapsed and the external reset has been released, whichever comes later.
- R9: Each of the four asynchronous inputs takes effect three clock edges after it changes at the pins: two synchroniser stages and then the state register.
- R10: The encoding on `dbg_state_o` is: power hold = 0, pulse = 1, run = 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| tick_i | input | 1 | Prescaled time-base enable, synchronous to clk_i |
| supply_ok_i | input | 1 | Supply-good comparator flag (asynchronous) |
| ext_rst_ni | input | 1 | Active-low external reset request (asynchronous) |
| ext_rst_i | input | 1 | Active-high external reset request (asynchronous) |
| ack_i | input | 1 | Address-acknowledge strobe from the bus slave (asynchronous) |
| reset_no | output | 1 | Active-low system reset |
| reset_o | output | 1 | Active-high system reset |
| dbg_state_o | output | 2 | Controller state code (0 hold, 1 pulse, 2 run) |

## Verification
The assertions assume that `tick_i` is already synchronous to the clock. They also assume that the asynchronous inputs stay stable for at least a clock cycle, so the synchroniser passes every level change through with exactly two cycles of delay. The bench drives every input on the falling edge and holds each change for at least one full cycle. This keeps the two-edge capture deterministic and lets the cycle-accurate reference model predict each transition.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_PULSE = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_e;

endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync #(
    parameter int          WIDTH     = 4,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q[g] <= RST_VAL;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/wdsup_edge.sv
module wdsup_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/wdsup_ctrl.sv
module wdsup_ctrl
    import wdsup_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 16,
    parameter int PULSE_TICKS   = 5
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       supply_ok_i,
    input  logic       ext_act_i,
    input  logic       kick_i,
    output logic       reset_o,
    output logic       reset_no,
    output logic [1:0] state_o
);

    localparam int WW = $clog2(TIMEOUT_TICKS + 1);
    localparam int PW = $clog2(PULSE_TICKS + 1);
    localparam logic [WW-1:0] WDT_LAST = WW'(TIMEOUT_TICKS - 1);
    localparam logic [PW-1:0] PCNT_END = PW'(PULSE_TICKS);

    typedef struct packed {
        sup_state_e    state;
        logic [WW-1:0] wdt;
        logic [PW-1:0] pcnt;
        logic          rst;
        logic          rstn;
    } regs_t;

    localparam regs_t REGS_RST = '{state: ST_HOLD, wdt: '0, pcnt: '0,
                                   rst: 1'b1, rstn: 1'b0};

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!supply_ok_i) begin
            r_d.state = ST_HOLD;
            r_d.wdt   = '0;
            r_d.pcnt  = '0;
        end else begin
            unique case (r_q.state)
                ST_HOLD: begin
                    r_d.state = ST_PULSE;
                    r_d.pcnt  = '0;
                end
                ST_PULSE: begin
                    if (tick_i && (r_q.pcnt != PCNT_END)) begin
                        r_d.pcnt = r_q.pcnt + 1'b1;
                    end
                    if ((r_q.pcnt == PCNT_END) && !ext_act_i) begin
                        r_d.state = ST_RUN;
                        r_d.wdt   = '0;
                    end
                end
                ST_RUN: begin
                    if (ext_act_i) begin
                        r_d.state = ST_PULSE;
                        r_d.pcnt  = '0;
                    end else if (kick_i) begin
                        r_d.wdt = '0;
                    end else if (tick_i) begin
                        if (r_q.wdt == WDT_LAST) begin
                            r_d.state = ST_PULSE;
                            r_d.pcnt  = '0;
                            r_d.wdt   = '0;
                        end else begin
                            r_d.wdt = r_q.wdt + 1'b1;
                        end
                    end
                end
                default: begin
                    r_d.state = ST_HOLD;
                end
            endcase
        end
        r_d.rst  = (r_d.state != ST_RUN);
        r_d.rstn = (r_d.state == ST_RUN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign reset_o  = r_q.rst;
    assign reset_no = r_q.rstn;
    assign state_o  = r_q.state;

    // R2: the two output registers never agree
    p_compl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_o != reset_no);

    // R2: active-high reset tracks the non-run states
    p_outstate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reset_o == (r_q.state != ST_RUN));

    // R3: a bad supply forces power hold on the next edge
    p_supply_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !supply_ok_i |=> (r_q.state == ST_HOLD));

    // R5: last tick of the window without service starts a pulse
    p_timeout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (supply_ok_i && r_q.state == ST_RUN && tick_i && !kick_i && !ext_act_i
         && r_q.wdt == WDT_LAST) |=> (r_q.state == ST_PULSE));

    // R6: a service edge in run restarts the window
    p_kick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (supply_ok_i && r_q.state == ST_RUN && kick_i && !ext_act_i)
        |=> (r_q.wdt == '0));

    // R7: a pulse never leaves early, service or not
    p_pulse_min_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_PULSE && r_q.pcnt != PCNT_END) |=> (r_q.state != ST_RUN));

    // R8: an active external request keeps the pulse going
    p_ext_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_PULSE && ext_act_i) |=> (r_q.state != ST_RUN));

    // R10: the unused encoding never appears
    p_enc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.state != 2'd3);

endmodule

// File: rtl/wdt_reset_supervisor.sv
module wdt_reset_supervisor #(
    parameter int TIMEOUT_TICKS = 16,
    parameter int PULSE_TICKS   = 5,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       tick_i,
    input  logic       supply_ok_i,
    input  logic       ext_rst_ni,
    input  logic       ext_rst_i,
    input  logic       ack_i,
    output logic       reset_no,
    output logic       reset_o,
    output logic [1:0] dbg_state_o
);

    localparam int NSYNC = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100;

    logic [NSYNC-1:0] raw_in, sync_in;
    logic             kick, ext_act;

    assign raw_in = {ack_i, ext_rst_ni, ext_rst_i, supply_ok_i};

    wdsup_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(raw_in),
        .sync_o (sync_in)
    );

    wdsup_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .level_i(sync_in[3]),
        .rise_o (kick)
    );

    assign ext_act = ~sync_in[2] | sync_in[1];

    wdsup_ctrl #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .PULSE_TICKS  (PULSE_TICKS)
    ) i_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick_i),
        .supply_ok_i(sync_in[0]),
        .ext_act_i  (ext_act),
        .kick_i     (kick),
        .reset_o    (reset_o),
        .reset_no   (reset_no),
        .state_o    (dbg_state_o)
    );

    // R6: a service strobe lasts exactly one cycle per rising edge
    p_kick_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        kick |=> !kick);

endmodule

// File: tb/test_wdt_reset_supervisor.sv
module test_wdt_reset_supervisor;

    localparam int CLK_PERIOD = 10;
    localparam int TOUT = 16;
    localparam int PTK  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sup = 1'b0;
    logic extn = 1'b1;
    logic ext = 1'b0;
    logic ack = 1'b0;
    logic reset_no, reset_o;
    logic [1:0] dbg;

    int checks = 0;
    int errors = 0;
    int tick_mode = 0;
    bit tick_on = 1'b1;
    string scen = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_reset_supervisor #(.TIMEOUT_TICKS(TOUT), .PULSE_TICKS(PTK)) i_wdt_reset_supervisor (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .supply_ok_i(sup),
        .ext_rst_ni(extn), .ext_rst_i(ext), .ack_i(ack),
        .reset_no(reset_no), .reset_o(reset_o), .dbg_state_o(dbg)
    );

    // tick generator: every cycle (mode 0) or every other cycle (mode 1)
    int tphase = 0;
    always @(negedge clk) begin
        tphase <= tphase + 1;
        tick <= tick_on && ((tick_mode == 0) || (tphase % 2 == 0));
    end

    // behavioural reference model: 0 hold, 1 pulse, 2 run
    bit ms1, ms2, me1, me2, mh1, mh2, ma1, ma2, maprev;
    int mst, mwdt, mpc;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ms1 = 0; ms2 = 0; me1 = 1; me2 = 1; mh1 = 0; mh2 = 0;
            ma1 = 0; ma2 = 0; maprev = 0; mst = 0; mwdt = 0; mpc = 0;
        end else begin
            bit xact, kick;
            xact = !me2 || mh2;
            kick = ma2 && !maprev;
            if (!ms2) begin
                mst = 0; mwdt = 0; mpc = 0;
            end else if (mst == 0) begin
                mst = 1; mpc = 0;
            end else if (mst == 1) begin
                bit done;
                done = (mpc == PTK);
                if (tick && mpc < PTK) mpc++;
                if (done && !xact) begin mst = 2; mwdt = 0; end
            end else begin
                if (xact) begin mst = 1; mpc = 0; end
                else if (kick) mwdt = 0;
                else if (tick) begin
                    if (mwdt + 1 == TOUT) begin mst = 1; mpc = 0; mwdt = 0; end
                    else mwdt++;
                end
            end
            maprev = ma2;
            ms2 = ms1; ms1 = sup;
            me2 = me1; me1 = extn;
            mh2 = mh1; mh1 = ext;
            ma2 = ma1; ma1 = ack;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R2, R9, R10)
    always @(negedge clk) begin
        if (rst_n) begin
            chk(scen, int'(dbg), mst, "state vs model");
            chk("R2", int'(reset_o), (mst != 2) ? 1 : 0, "reset_o");
            chk("R2", int'(reset_no), (mst == 2) ? 1 : 0, "reset_no");
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_state(input int target, input int limit, output bit found);
        found = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (dbg == 2'(target)) begin found = 1; break; end
        end
    endtask

    // counts consecutive cycles in target, starting at the current one
    task automatic run_len(input int target, output int n);
        n = 0;
        while (dbg == 2'(target) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic kick_once();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic done();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done();
    end

    bit spam = 0;
    initial begin
        bit f;
        int n;
        // R1: reset values
        cyc(2);
        chk("R1", int'(dbg), 0, "reset state");
        chk("R1", int'(reset_o), 1, "reset_o in reset");
        chk("R1", int'(reset_no), 0, "reset_no in reset");
        @(negedge clk); rst_n = 1'b1;

        // R3: supply low keeps power hold
        scen = "R3";
        cyc(30);
        chk("R3", int'(dbg), 0, "hold with bad supply");

        // R4: power-up pulse length
        scen = "R4";
        @(negedge clk); sup = 1'b1;
        wait_state(1, 10, f);
        chk("R4", int'(f), 1, "pulse entered");
        run_len(1, n);
        chk("R4", n, PTK + 1, "power-up pulse length");
        chk("R4", int'(dbg), 2, "run after pulse");

        // R6: periodic service keeps run (both tick modes)
        scen = "R6";
        for (int k = 0; k < 10; k++) begin kick_once(); cyc(8); end
        tick_mode = 1;
        for (int k = 0; k < 6; k++) begin kick_once(); cyc(20); end
        chk("R6", int'(dbg), 2, "still running with service");
        tick_mode = 0;
        kick_once();

        // R5/R6: held acknowledge counts once, so timeout follows
        scen = "R5";
        @(negedge clk); ack = 1'b1;
        cyc(TOUT - 2);
        chk("R6", int'(dbg), 2, "no early timeout");
        wait_state(1, 40, f);
        chk("R5", int'(f), 1, "timeout with held ack");
        @(negedge clk); ack = 1'b0;
        wait_state(2, 40, f);

        // R7: acknowledge spam during pulse has no effect
        scen = "R7";
        wait_state(1, 40, f);
        chk("R5", int'(f), 1, "timeout without service");
        spam = 1;
        fork
            begin
                while (spam) begin @(negedge clk); ack = ~ack; end
                ack = 1'b0;
            end
            begin run_len(1, n); spam = 0; end
        join
        chk("R7", n, PTK + 1, "pulse length with ack spam");

        // R8: long active-low external reset stretches the pulse
        scen = "R8";
        kick_once();
        @(negedge clk); extn = 1'b0;
        wait_state(1, 6, f);
        chk("R8", int'(f), 1, "ext_rst_ni starts pulse");
        cyc(16); extn = 1'b1;
        run_len(1, n);
        chk("R8", int'(dbg), 2, "run after ext release");
        // R8: short active-high request still gets the full pulse
        kick_once();
        @(negedge clk); ext = 1'b1;
        @(negedge clk); ext = 1'b0;
        wait_state(1, 6, f);
        chk("R8", int'(f), 1, "ext_rst_i starts pulse");
        run_len(1, n);
        chk("R8", n, PTK + 1, "short ext pulse length");

        // R9: supply loss reaches state three edges later
        scen = "R9";
        kick_once();
        @(negedge clk); sup = 1'b0;
        cyc(2);
        chk("R9", int'(dbg), 2, "not yet held after two edges");
        cyc(1);
        chk("R3", int'(dbg), 0, "hold after supply loss");
        cyc(5);
        chk("R10", int'(reset_o), 1, "reset while held");
        scen = "R4";
        @(negedge clk); sup = 1'b1;
        wait_state(2, 40, f);
        chk("R4", int'(f), 1, "recovery to run");
        cyc(5);
        done();
    end

endmodule